// File: doc/BRIEF.md
# Addressed Serial Register-Port Slave

This block lets a host microcontroller write and read a bank of sixteen 8-bit registers over a four-wire SPI link. The link has an active-low select, a bit clock, a data line in and a data line out. The output pad is driven only while read data is being returned, so several devices can share the bus. A two-bit strap input gives each device its own bus address, so up to four devices can sit on one set of wires.

Every transaction opens with a header byte, sent most significant bit first. The first five bits are zero. Bits six and seven carry the target address, high bit first, and the last bit is the direction flag (0 = write, 1 = read). A write header is followed by a pointer byte and then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps up by one. A read header is followed by bytes that the device shifts out, starting at the pointer left by the previous access. The pointer steps up after each byte.

The link signals are brought into the chip clock domain through synchronizers, and all state runs on the chip clock. Bit edges are found from the synchronized bit clock. The bit clock must be slow enough that each of its phases lasts several chip clock cycles.

Top module: `spi_regport`

## Requirements
- R1: After reset, sdo_oe is low, all sixteen registers read as 0x00 and the pointer is 0.
- R2: A header is sent MSB first as bits 7..3 = 0, bit 2 = address high, bit 1 = address low, bit 0 = direction (1 = read, 0 = write). A header that matches the strap starts the transfer in the direction its flag gives.
- R3: A header whose address bits differ from the strap is ignored until select rises. No register or pointer changes, and sdo_oe stays low.
- R4: A header with any of bits 7..3 set is ignored in the same way as R3.
- R5: In a write, the byte after the header loads the pointer from its low four bits; its upper four bits are ignored. Each following data byte is stored in the register the pointer names.
- R6: The pointer steps up by one after each data byte, whether written or read, and wraps from 15 to 0.
- R7: In a read, the device shifts out the register the pointer names, MSB first. sdo changes only after a falling edge of the bit clock, so it is stable at the following rising edge. A later read continues from the pointer where the last access left it.
- R8: sdo_oe rises only in the data phase of a matched read. It is low during every header, and it falls within a few chip clocks after select goes high.
- R9: Select going high at any point ends the transaction. A partly received byte is discarded and has no effect. The next low select starts a fresh header.
- R10: If select rises in the same chip clock as the rising bit-clock edge that would complete a write data byte, the abort wins and the byte is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 2 | Bus address of this device |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial bit clock, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the sdo pad |

## Verification
Two events can meet in one chip clock: the rising bit-clock edge that commits the last bit of a write data byte, and the rise of select that aborts the transaction. The bench provokes this by raising sclk and cs_n in the same instant on the eighth bit of a data byte. Both signals pass through identical synchronizers, so they arrive in the same cycle. The bench then reads that register back and expects its earlier contents, because the abort takes priority over the commit.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int NREG = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe
);
  localparam int AW = $clog2(NREG);
  localparam logic [2:0] S_HDR = 3'd0, S_PTR = 3'd1, S_WR = 3'd2, S_RD = 3'd3, S_IGN = 3'd4;

  logic [SYNC-1:0] cs_p, ck_p, di_p;
  logic            ck_q;
  logic            cs_s, sck_s, sdi_s, rise, fall;
  logic [2:0]      st, bcnt, fcnt;
  logic [7:0]      sh, tx, byte_in;
  logic [AW-1:0]   ptr;
  logic            sdo_r, oe_r;
  logic [7:0]      regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '1;
      ck_p <= '0;
      di_p <= '0;
      ck_q <= 1'b0;
    end else begin
      cs_p <= {cs_p[SYNC-2:0], cs_n};
      ck_p <= {ck_p[SYNC-2:0], sclk};
      di_p <= {di_p[SYNC-2:0], sdi};
      ck_q <= ck_p[SYNC-1];
    end
  end

  assign cs_s    = cs_p[SYNC-1];
  assign sck_s   = ck_p[SYNC-1];
  assign sdi_s   = di_p[SYNC-1];
  assign rise    = sck_s & ~ck_q;
  assign fall    = ~sck_s & ck_q;
  assign byte_in = {sh[6:0], sdi_s};
  assign sdo     = sdo_r;
  assign sdo_oe  = oe_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_HDR;
      bcnt  <= '0;
      fcnt  <= '0;
      sh    <= '0;
      tx    <= '0;
      ptr   <= '0;
      sdo_r <= 1'b0;
      oe_r  <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (cs_s) begin
      st   <= S_HDR;
      bcnt <= '0;
      fcnt <= '0;
      oe_r <= 1'b0;
    end else begin
      if (rise) begin
        sh   <= byte_in;
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          case (st)
            S_HDR: begin
              if (byte_in[7:3] != 5'd0 || byte_in[2:1] != strap) st <= S_IGN;
              else st <= byte_in[0] ? S_RD : S_PTR;
            end
            S_PTR: begin
              ptr <= byte_in[AW-1:0];
              st  <= S_WR;
            end
            S_WR: begin
              regs[ptr] <= byte_in;
              ptr       <= ptr + 1'b1;
            end
            S_RD:    ptr <= ptr + 1'b1;
            default: ;
          endcase
        end
      end
      if (fall && st == S_RD) begin
        oe_r <= 1'b1;
        fcnt <= fcnt + 3'd1;
        if (fcnt == 3'd0) begin
          sdo_r <= regs[ptr][7];
          tx    <= {regs[ptr][6:0], 1'b0};
        end else begin
          sdo_r <= tx[7];
          tx    <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

module spi_regport_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          rise,
  input logic          fall,
  input logic [2:0]    st,
  input logic [2:0]    bcnt,
  input logic [AW-1:0] ptr,
  input logic          sdo,
  input logic          sdo_oe
);
  // R8
  oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe);
  // R8
  oe_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> st == 3'd3);
  // R6
  wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && rise && bcnt == 3'd7 && st == 3'd2) |=> ptr == AW'($past(ptr) + 1'b1));
  // R3
  ignore_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && !cs_s) |=> st == 3'd4);
  // R9
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bcnt == 3'd0 && st == 3'd0));
  // R7
  sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo));
endmodule

bind spi_regport spi_regport_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise(rise), .fall(fall),
  .st(st), .bcnt(bcnt), .ptr(ptr), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] strap = 2'd1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;

  int compared = 0, mismatched = 0;
  logic [7:0] mdl [16];
  int mptr = 0;
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic [7:0] got;
  event got_ev;

  always #5 clk = ~clk;

  spi_regport u0 (.clk(clk), .rst_n(rst_n), .strap(strap), .cs_n(cs_n),
                  .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected byte", got, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, got, e);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r,
                           output bit oeall, output bit oeany);
    oeall = 1'b1;
    oeany = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sdi = b[i];
      wait_clk(8);
      r[i] = sdo;
      oeall &= sdo_oe;
      oeany |= sdo_oe;
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
    end
  endtask

  task automatic begin_tx;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(8);
  endtask

  task automatic end_tx;
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic wr_burst(input logic [1:0] a, input logic [7:0] p, input logic [7:0] d [$]);
    logic [7:0] r;
    bit oa, on;
    bit hit = (a == strap);
    begin_tx;
    send_byte({5'b0, a, 1'b0}, r, oa, on);
    send_byte(p, r, oa, on);
    if (hit) mptr = p[3:0];
    foreach (d[i]) begin
      send_byte(d[i], r, oa, on);
      chk(!on, "R8 write oe", on, 0);
      if (hit) begin
        mdl[mptr] = d[i];
        mptr = (mptr + 1) % 16;
      end
    end
    end_tx;
  endtask

  task automatic rd_burst(input logic [7:0] hdr, input int n, input string req);
    logic [7:0] r;
    bit oa, on;
    bit hit = (hdr[7:3] == 5'd0) && (hdr[2:1] == strap);
    begin_tx;
    send_byte(hdr, r, oa, on);
    chk(!on, "R8 header oe", on, 0);
    for (int i = 0; i < n; i++) begin
      if (hit) begin
        exp_q.push_back(mdl[mptr]);
        tag_q.push_back(req);
      end
      send_byte(8'h00, r, oa, on);
      if (hit) begin
        got = r;
        ->got_ev;
        chk(oa, "R8 read oe", oa, 1);
        mptr = (mptr + 1) % 16;
      end else chk(!on, "R3/R4 ignored oe", on, 0);
    end
    end_tx;
    chk(sdo_oe == 1'b0, "R8 oe after select", sdo_oe, 0);
  endtask

  initial begin
    wait_clk(150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] r;
    bit oa, on;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    wait_clk(4);
    chk(sdo_oe == 1'b0, "R1 reset oe", sdo_oe, 0);
    rst_n = 1'b1;
    wait_clk(4);
    chk(sdo_oe == 1'b0, "R1 idle oe", sdo_oe, 0);

    // R1: all zero from pointer 0, full sweep wraps back (R6)
    rd_burst({5'b0, 2'd1, 1'b1}, 17, "R1 reset contents");

    // R5 + R7: write three bytes at 3, reposition, read back
    wr_burst(2'd1, 8'h03, '{8'hA5, 8'h3C, 8'hFF});
    wr_burst(2'd1, 8'h03, '{});
    rd_burst({5'b0, 2'd1, 1'b1}, 3, "R5 R7 burst readback");

    // R7: pointer continues across separate reads
    rd_burst({5'b0, 2'd1, 1'b1}, 2, "R7 continued read");

    // R6: wrap 14,15,0,1
    wr_burst(2'd1, 8'h0E, '{8'h11, 8'h22, 8'h33, 8'h44});
    wr_burst(2'd1, 8'h0E, '{});
    rd_burst({5'b0, 2'd1, 1'b1}, 4, "R6 wrap");

    // R5: upper pointer bits ignored
    wr_burst(2'd1, 8'hF5, '{8'h5A});
    wr_burst(2'd1, 8'h05, '{});
    rd_burst({5'b0, 2'd1, 1'b1}, 1, "R5 pointer low bits");

    // R3: other addresses write and read nothing
    wr_burst(2'd2, 8'h00, '{8'h99, 8'h98});
    wr_burst(2'd0, 8'h00, '{8'h97});
    rd_burst({5'b0, 2'd3, 1'b1}, 2, "R3 mismatch read");
    wr_burst(2'd1, 8'h00, '{});
    rd_burst({5'b0, 2'd1, 1'b1}, 2, "R3 registers untouched");

    // R4: nonzero prefix ignored
    begin_tx;
    send_byte({5'b00100, 2'd1, 1'b0}, r, oa, on);
    send_byte(8'h00, r, oa, on);
    send_byte(8'hEE, r, oa, on);
    chk(!on, "R4 bad prefix oe", on, 0);
    end_tx;
    rd_burst({5'b10000, 2'd1, 1'b1}, 1, "R4 bad prefix read");
    wr_burst(2'd1, 8'h00, '{});
    rd_burst({5'b0, 2'd1, 1'b1}, 1, "R4 register untouched");

    // R2: change strap, address 2 now answers
    strap = 2'd2;
    wr_burst(2'd2, 8'h09, '{8'hC3});
    wr_burst(2'd2, 8'h09, '{});
    rd_burst({5'b0, 2'd2, 1'b1}, 1, "R2 strap 2");

    // R9: abort in the middle of a data byte
    mdl[7] = 8'h07;
    wr_burst(2'd2, 8'h07, '{8'h07});
    begin_tx;
    send_byte({5'b0, 2'd2, 1'b0}, r, oa, on);
    send_byte(8'h07, r, oa, on);
    mptr = 7;
    for (int i = 7; i >= 4; i--) begin
      @(negedge clk);
      sdi = 1'b1;
      wait_clk(8);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
    end
    end_tx;
    rd_burst({5'b0, 2'd2, 1'b1}, 1, "R9 partial byte dropped");

    // R10: select rise coincides with the committing edge
    begin_tx;
    send_byte({5'b0, 2'd2, 1'b0}, r, oa, on);
    send_byte(8'h08, r, oa, on);
    mptr = 8;
    for (int i = 7; i >= 1; i--) begin
      @(negedge clk);
      sdi = 1'b1;
      wait_clk(8);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
    end
    @(negedge clk);
    sdi = 1'b1;
    wait_clk(8);
    sclk = 1'b1;
    cs_n = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
    wait_clk(8);
    rd_burst({5'b0, 2'd2, 1'b1}, 1, "R10 abort beats commit");

    // R9: fresh header works after aborts
    wr_burst(2'd2, 8'h08, '{8'h81});
    wr_burst(2'd2, 8'h08, '{});
    rd_burst({5'b0, 2'd2, 1'b1}, 1, "R9 recovery");

    wait_clk(20);
    chk(exp_q.size() == 0, "R7 pending bytes", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule